// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one processor's request port and a simple word-addressed memory port and gives that processor an atomic read-modify-write primitive. A load-linked request reads a word and records the cache block that holds it in a reservation register, setting a valid flag. A later store-conditional writes memory only if that reservation is still alive for the same block. It answers the requester with 1 on success and 0 on failure. Ordinary loads and stores pass straight through.

The reservation is killed by several events: a write by another agent to the reserved block (seen on a snoop input), a context-switch pulse, an eviction of the reserved block, an ordinary store by the owner into that block, and any store-conditional, whether it succeeds or fails. A failed store-conditional leaves the memory port idle. Addresses are compared at block granularity: the low `OFFW` address bits select a word inside a block and are ignored.

A controller state machine handles each request. It has four states. In `ST_IDLE` it accepts a request. It then moves to `ST_RD_DATA` for a load or load-linked, to `ST_WR_DONE` for a store, or to `ST_SC_DONE` for a store-conditional. Each of the three response states returns to `ST_IDLE` after one cycle.

Top module: `llsc_monitor`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_op` is encoded as 00 load, 01 store, 10 load-linked, 11 store-conditional. In the next cycle `rsp_valid` is high for exactly one cycle and `req_ready` is low.
- R2: A load or load-linked drives `mem_rd_en` with `mem_addr` = `req_addr` in the accept cycle. The response carries the word that memory returns one cycle later. A plain store writes in the accept cycle and responds with 0.
- R3: A load-linked arms the reservation for block `req_addr[AW-1:OFFW]`. It is left unarmed if a clearing event hits that block in the same cycle.
- R4: A store-conditional succeeds only when the reservation is armed and its block equals `req_addr[AW-1:OFFW]`. Any word of the block counts. On success it writes `req_wdata` and responds 1. Otherwise it responds 0.
- R5: A failed store-conditional keeps `mem_wr_en` and `mem_rd_en` low in its accept cycle.
- R6: A `snoop_wr` whose block equals the reserved block clears the reservation. A snoop to any other block leaves it intact.
- R7: A `ctx_switch` pulse clears the reservation.
- R8: An `evict` whose block equals the reserved block clears the reservation. An eviction of another block leaves it intact.
- R9: Every store-conditional consumes the reservation, whether it succeeds or fails.
- R10: An ordinary store by the owner into the reserved block clears the reservation.
- R11: A snoop write to the reserved block in the same cycle as a store-conditional makes the store-conditional fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_op | input | 2 | Operation: 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | AW (8) | Word address |
| req_wdata | input | DW (32) | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW (32) | Load data, 1/0 conditional outcome, or 0 for store |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW (8) | Memory word address |
| mem_wdata | output | DW (32) | Memory write data |
| mem_rdata | input | DW (32) | Read data, valid one cycle after the read strobe |
| snoop_wr | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | AW-OFFW (6) | Block number of that write |
| ctx_switch | input | 1 | Context-switch pulse |
| evict | input | 1 | Line eviction pulse |
| evict_addr | input | AW-OFFW (6) | Block number being evicted |

## Verification
The two functions that can land in the same cycle are a store-conditional decision and the clearing of the reservation by a remote write. The bench provokes the collision by raising `snoop_wr` on the reserved block in the very cycle that a store-conditional is presented. It judges the result three ways: the response must be 0, `mem_wr_en` must stay low in that cycle, and a follow-up load must return the snooped value.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } llsc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_DATA,
        ST_WR_DONE,
        ST_SC_DONE
    } llsc_state_e;

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int AW   = 8,
    parameter int OFFW = 2,
    localparam int TW  = AW - OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [TW-1:0] arm_tag,
    input  logic          consume,
    input  logic          own_wr,
    input  logic [TW-1:0] req_tag,
    input  logic          snoop_wr,
    input  logic [TW-1:0] snoop_tag,
    input  logic          ctx_switch,
    input  logic          evict,
    input  logic [TW-1:0] evict_tag,
    output logic          probe_ok
);

    logic          valid_q;
    logic [TW-1:0] tag_q;
    logic          snoop_hit, evict_hit, own_hit, kill, arm_blocked;

    always_comb begin
        snoop_hit   = snoop_wr && (snoop_tag == tag_q);
        evict_hit   = evict && (evict_tag == tag_q);
        own_hit     = own_wr && (req_tag == tag_q);
        kill        = ctx_switch || snoop_hit || evict_hit || own_hit || consume;
        arm_blocked = ctx_switch || (snoop_wr && snoop_tag == arm_tag)
                      || (evict && evict_tag == arm_tag);
        probe_ok    = valid_q && (req_tag == tag_q) && !ctx_switch
                      && !snoop_hit && !evict_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (arm) begin
            valid_q <= !arm_blocked;
            tag_q   <= arm_tag;
        end else if (kill) begin
            valid_q <= 1'b0;
        end
    end

    // R7
    ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> !valid_q);

    // R9
    consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !valid_q);

    // R3
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !arm_blocked) |=> (valid_q && tag_q == $past(arm_tag)));

    // R6
    snoop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_wr && valid_q && snoop_tag == tag_q && !arm) |=> !valid_q);

endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
    import llsc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          sc_ok,
    output logic          arm,
    output logic          consume,
    output logic          own_wr
);

    llsc_state_e state_q, state_d;
    llsc_op_e    op;
    logic        accept;
    logic        sc_res_q;

    assign op     = llsc_op_e'(req_op);
    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_LOAD, OP_LL: state_d = ST_RD_DATA;
                        OP_STORE:       state_d = ST_WR_DONE;
                        OP_SC:          state_d = ST_SC_DONE;
                    endcase
                end
            end
            ST_RD_DATA, ST_WR_DONE, ST_SC_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sc_res_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && op == OP_SC) sc_res_q <= sc_ok;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q != ST_IDLE);
        unique case (state_q)
            ST_RD_DATA: rsp_rdata = mem_rdata;
            ST_SC_DONE: rsp_rdata = {{(DW-1){1'b0}}, sc_res_q};
            default:    rsp_rdata = '0;
        endcase
        mem_rd_en = accept && (op == OP_LOAD || op == OP_LL);
        mem_wr_en = accept && (op == OP_STORE || (op == OP_SC && sc_ok));
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        arm       = accept && (op == OP_LL);
        consume   = accept && (op == OP_SC);
        own_wr    = accept && (op == OP_STORE);
    end

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp_valid && !req_ready));

    // R1
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    sc_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !sc_ok) |-> (!mem_wr_en && !mem_rd_en));

    // R4
    sc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (rsp_rdata == {{(DW-1){1'b0}}, $past(sc_ok)}));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int OFFW = 2,
    localparam int TW  = AW - OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          snoop_wr,
    input  logic [TW-1:0] snoop_addr,
    input  logic          ctx_switch,
    input  logic          evict,
    input  logic [TW-1:0] evict_addr
);

    logic sc_ok, arm, consume, own_wr;

    llsc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .sc_ok     (sc_ok),
        .arm       (arm),
        .consume   (consume),
        .own_wr    (own_wr)
    );

    llsc_resv #(.AW(AW), .OFFW(OFFW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .arm_tag    (req_addr[AW-1:OFFW]),
        .consume    (consume),
        .own_wr     (own_wr),
        .req_tag    (req_addr[AW-1:OFFW]),
        .snoop_wr   (snoop_wr),
        .snoop_tag  (snoop_addr),
        .ctx_switch (ctx_switch),
        .evict      (evict),
        .evict_tag  (evict_addr),
        .probe_ok   (sc_ok)
    );

endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;

    localparam int AW = 8, DW = 32, OFFW = 2, TW = AW - OFFW;
    localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          snoop_wr = 1'b0;
    logic [AW-1:0] snoop_word = '0;
    logic [DW-1:0] snoop_data = '0;
    logic          ctx_switch = 1'b0, evict = 1'b0;
    logic [TW-1:0] evict_addr = '0;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [DW-1:0] expq[$];
    string         tagq[$];
    logic [DW-1:0] mem [256];

    always #10 clk = ~clk;

    llsc_monitor #(.AW(AW), .DW(DW), .OFFW(OFFW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_word[AW-1:OFFW]),
        .ctx_switch(ctx_switch), .evict(evict), .evict_addr(evict_addr)
    );

    // shared memory model: processor port plus a second writing agent
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr];
            if (mem_wr_en) mem[mem_addr] <= mem_wdata;
            if (snoop_wr)  mem[snoop_word] <= snoop_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R1 unexpected response", rsp_rdata, '0);
            end else begin
                automatic logic [DW-1:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                chk(rsp_rdata === e && !req_ready, t, rsp_rdata, e);
            end
        end
    end

    // driver: called at a negedge, returns at a negedge with the controller idle
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [DW-1:0] exp,
                         input bit exp_wr, input string req);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        expq.push_back(exp); tagq.push_back(req);
        #5;
        chk(mem_wr_en === exp_wr, req, {31'b0, mem_wr_en}, {31'b0, exp_wr});
        if (op == SC && !exp_wr)
            chk(mem_rd_en === 1'b0, "R5 no read on failed conditional",
                {31'b0, mem_rd_en}, '0);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
        snoop_wr = 1'b1; snoop_word = a; snoop_data = d;
        @(negedge clk); snoop_wr = 1'b0;
    endtask

    task automatic do_evict(input logic [AW-1:0] a);
        evict = 1'b1; evict_addr = a[AW-1:OFFW];
        @(negedge clk); evict = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_wr_en === 1'b0,
            "R1 reset state", {29'b0, req_ready, rsp_valid, mem_wr_en}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        issue(ST, 8'h10, 32'd5, 32'd0, 1, "R2 plain store");
        issue(LL, 8'h10, '0, 32'd5, 0, "R2 load-linked data");
        issue(SC, 8'h10, 32'd6, 32'd1, 1, "R4 conditional success");
        issue(LD, 8'h10, '0, 32'd6, 0, "R4 stored value");
        // R9 consumed after success
        issue(SC, 8'h10, 32'd9, 32'd0, 0, "R9 second conditional fails");
        issue(LD, 8'h10, '0, 32'd6, 0, "R5 memory untouched");
        // R4 other block
        issue(LL, 8'h10, '0, 32'd6, 0, "R3 arm");
        issue(SC, 8'h14, 32'd7, 32'd0, 0, "R4 other block fails");
        // R9 consumed after failure
        issue(LL, 8'h10, '0, 32'd6, 0, "R3 arm");
        issue(SC, 8'h14, 32'd7, 32'd0, 0, "R4 other block fails");
        issue(SC, 8'h10, 32'd7, 32'd0, 0, "R9 failed conditional consumed");
        // R4 same block different word succeeds
        issue(LL, 8'h11, '0, 32'd0, 0, "R3 arm word 1");
        issue(SC, 8'h12, 32'd8, 32'd1, 1, "R4 block granularity success");
        // R6 snoop in block
        issue(LL, 8'h10, '0, 32'd6, 0, "R3 arm");
        snoop(8'h13, 32'd99);
        issue(SC, 8'h10, 32'd7, 32'd0, 0, "R6 snoop in block kills");
        issue(LD, 8'h13, '0, 32'd99, 0, "R6 snoop data landed");
        // R6 snoop elsewhere
        issue(LL, 8'h10, '0, 32'd6, 0, "R3 arm");
        snoop(8'h20, 32'd44);
        issue(SC, 8'h10, 32'd7, 32'd1, 1, "R6 snoop elsewhere harmless");
        // R7 context switch
        issue(LL, 8'h10, '0, 32'd7, 0, "R3 arm");
        ctx_switch = 1'b1; @(negedge clk); ctx_switch = 1'b0;
        issue(SC, 8'h10, 32'd3, 32'd0, 0, "R7 context switch kills");
        // R8 eviction
        issue(LL, 8'h10, '0, 32'd7, 0, "R3 arm");
        do_evict(8'h11);
        issue(SC, 8'h10, 32'd3, 32'd0, 0, "R8 eviction kills");
        issue(LL, 8'h10, '0, 32'd7, 0, "R3 arm");
        do_evict(8'h30);
        issue(SC, 8'h10, 32'd3, 32'd1, 1, "R8 other eviction harmless");
        // R10 own store
        issue(LL, 8'h10, '0, 32'd3, 0, "R3 arm");
        issue(ST, 8'h12, 32'd55, 32'd0, 1, "R10 own store");
        issue(SC, 8'h10, 32'd4, 32'd0, 0, "R10 own store kills");
        // R11 collision: snoop and conditional in the same cycle
        issue(LL, 8'h10, '0, 32'd3, 0, "R3 arm");
        snoop_wr = 1'b1; snoop_word = 8'h10; snoop_data = 32'd77;
        issue(SC, 8'h10, 32'd4, 32'd0, 0, "R11 remote write wins");
        snoop_wr = 1'b0;
        issue(LD, 8'h10, '0, 32'd77, 0, "R11 remote value kept");
        // R3 arming blocked by same-cycle context switch
        ctx_switch = 1'b1;
        issue(LL, 8'h10, '0, 32'd77, 0, "R3 arm with context switch");
        ctx_switch = 1'b0;
        issue(SC, 8'h10, 32'd4, 32'd0, 0, "R3 arm blocked");

        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R1 all responses seen", expq.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule